// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block sits between a processor's address path and a page table kept in memory. It holds a few recent page-to-frame mappings in a fully associative array. Each entry is tagged with the address-space identifier of the process that owns it. A lookup presents a virtual page number, the current identifier and an access type. When a stored entry matches both tags, the frame number and a permission verdict come back on the next cycle.

On a miss the block first checks the page number against the table length input. It then issues one read to the memory port at the table base plus the page number. While that read is outstanding, further requests stall. The returned entry is checked and, when valid, installed into a free slot. If no slot is free, it replaces the least recently used slot that is not pinned. A context switch needs nothing from the block beyond new values on the table base, table length and identifier inputs. Maintenance inputs remove one mapping by identifier and page, or drop every mapping that is not pinned.

Top module: `xlate_cache`

## Requirements
- R1: After reset no mapping is held, `req_ready` is 1, and `rsp_valid` and `mem_rd` are 0. The first lookup of any page therefore misses.
- R2: Suppose an accepted request (`req_valid` and `req_ready` high at a clock edge) matches a held mapping on both page number and identifier. Then `rsp_valid` is high in the next cycle with the stored frame, and no memory read is issued.
- R3: A held mapping matches only requests carrying the same identifier. The same page under another identifier misses.
- R4: On a miss within range, `mem_rd` is high for exactly one cycle, starting the cycle after acceptance, with `mem_addr` = `pt_base` + page number. `req_ready` stays low and requests are ignored until the cycle after `mem_rvalid`.
- R5: The table entry format is: frame in bits [PFN_W-1:0], read at PFN_W, write at PFN_W+1, execute at PFN_W+2, valid at PFN_W+3 and pin at PFN_W+4. The response comes the cycle after `mem_rvalid`. A valid entry is installed, so a repeat of the lookup hits.
- R6: A fetched entry whose valid bit is clear gives response code 1 with frame 0. It is not installed, so a repeat of the lookup reads memory again.
- R7: Access types are encoded 0 read, 1 write, 2 execute; code 3 is always refused. An access that the entry's permission bits refuse gets code 2 with frame 0. This applies both on a hit and on a fill. A permitted access gets code 0.
- R8: A page number equal to or above `pt_len` gets code 3 in the next cycle, with frame 0 and no memory read.
- R9: A `flush` pulse removes every held mapping that is not pinned. Pinned mappings keep hitting.
- R10: An invalidate request removes the mapping with the given identifier and page, even when it is pinned. Other mappings stay.
- R11: A fill takes a free slot when one exists. Otherwise it evicts the least recently used slot that is not pinned; both hits and fills count as uses. A pinned slot is never evicted.
- R12: A lookup that coincides with an invalidate or flush sees the contents from before that cycle. A fill that coincides with a flush is still installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vpn | input | VPN_W | Virtual page number |
| req_asid | input | ASID_W | Current address-space identifier |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 ok, 1 no page, 2 denied, 3 out of range |
| rsp_pfn | output | PFN_W | Frame number, 0 on any fault |
| pt_base | input | PA_W | Page table base address |
| pt_len | input | VPN_W+1 | Page table length in entries |
| mem_rd | output | 1 | Table read strobe |
| mem_addr | output | PA_W | Table read address |
| mem_rvalid | input | 1 | Table read data strobe |
| mem_rdata | input | PFN_W+5 | Table entry |
| inv_valid | input | 1 | Invalidate one mapping |
| inv_vpn | input | VPN_W | Page to invalidate |
| inv_asid | input | ASID_W | Identifier to invalidate |
| flush | input | 1 | Drop all mappings that are not pinned |

## Verification
Two pairs of events can land on one clock edge. A lookup can arrive with an invalidate or flush of the very mapping it targets. A fill can return in the cycle a flush is raised. The bench drives the first pair on the same negative edge and expects a hit. It then repeats the lookup and expects a memory read. For the second pair it raises `flush` together with `mem_rvalid`, then expects the refilled page to hit with no memory read.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  localparam logic [1:0] RSP_OK     = 2'd0;
  localparam logic [1:0] RSP_NOPAGE = 2'd1;
  localparam logic [1:0] RSP_DENY   = 2'd2;
  localparam logic [1:0] RSP_RANGE  = 2'd3;

  function automatic logic perm_ok(input logic [1:0] acc, input logic r, input logic w,
                                   input logic x);
    case (acc)
      ACC_RD:  perm_ok = r;
      ACC_WR:  perm_ok = w;
      ACC_EX:  perm_ok = x;
      default: perm_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/xc_match.sv
module xc_match #(
  parameter int N      = 4,
  parameter int VPN_W  = 8,
  parameter int ASID_W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             vld,
  input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [N-1:0][ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic                     hit,
  output logic [IDX_W-1:0]         idx
);
  logic [N-1:0] vec;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign vec[i] = vld[i] && (ent_vpn[i] == key_vpn) && (ent_asid[i] == key_asid);
  end

  assign hit = |vec;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xc_lru.sv
module xc_lru #(
  parameter int N      = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     vld,
  input  logic [N-1:0]     pin,
  output logic             vic_ok,
  output logic [IDX_W-1:0] vic_idx
);
  logic [IDX_W-1:0] age_q [N];
  logic [IDX_W-1:0] best;
  logic             free_found;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    vic_ok     = 1'b0;
    vic_idx    = '0;
    best       = '0;
    free_found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!vld[i] && !free_found) begin
        free_found = 1'b1;
        vic_ok     = 1'b1;
        vic_idx    = IDX_W'(i);
      end
    end
    if (!free_found) begin
      for (int i = 0; i < N; i++) begin
        if (!pin[i] && (!vic_ok || age_q[i] > best)) begin
          vic_ok  = 1'b1;
          vic_idx = IDX_W'(i);
          best    = age_q[i];
        end
      end
    end
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xc_pkg::*;
#(
  parameter int N      = 4,
  parameter int VPN_W  = 8,
  parameter int PFN_W  = 8,
  parameter int ASID_W = 4,
  parameter int PA_W   = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int PTE_W = PFN_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [1:0]        req_acc,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [PFN_W-1:0]  rsp_pfn,
  input  logic [PA_W-1:0]   pt_base,
  input  logic [VPN_W:0]    pt_len,
  output logic              mem_rd,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata,
  input  logic              inv_valid,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              flush
);
  localparam int B_R   = PFN_W;
  localparam int B_W   = PFN_W + 1;
  localparam int B_X   = PFN_W + 2;
  localparam int B_V   = PFN_W + 3;
  localparam int B_PIN = PFN_W + 4;

  logic [N-1:0]             e_vld, e_pin, e_r, e_w, e_x;
  logic [N-1:0][VPN_W-1:0]  e_vpn;
  logic [N-1:0][ASID_W-1:0] e_asid;
  logic [N-1:0][PFN_W-1:0]  e_pfn;

  logic              busy;
  logic [VPN_W-1:0]  pend_vpn;
  logic [ASID_W-1:0] pend_asid;
  logic [1:0]        pend_acc;

  logic             lk_hit, iv_hit, vic_ok, touch, accept, in_range, fill, hit_ok, fill_ok;
  logic [IDX_W-1:0] lk_idx, iv_idx, vic_idx, touch_idx;

  xc_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lookup (
    .vld(e_vld), .ent_vpn(e_vpn), .ent_asid(e_asid),
    .key_vpn(req_vpn), .key_asid(req_asid), .hit(lk_hit), .idx(lk_idx));

  xc_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_inval (
    .vld(e_vld), .ent_vpn(e_vpn), .ent_asid(e_asid),
    .key_vpn(inv_vpn), .key_asid(inv_asid), .hit(iv_hit), .idx(iv_idx));

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign in_range  = {1'b0, req_vpn} < pt_len;
  assign fill      = busy && mem_rvalid && mem_rdata[B_V];
  assign hit_ok    = perm_ok(req_acc, e_r[lk_idx], e_w[lk_idx], e_x[lk_idx]);
  assign fill_ok   = perm_ok(pend_acc, mem_rdata[B_R], mem_rdata[B_W], mem_rdata[B_X]);
  assign touch     = (accept && in_range && lk_hit) || (fill && vic_ok);
  assign touch_idx = fill ? vic_idx : lk_idx;

  xc_lru #(.N(N)) u_lru (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .vld(e_vld), .pin(e_pin & e_vld), .vic_ok(vic_ok), .vic_idx(vic_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      e_vld     <= '0;
      e_pin     <= '0;
      e_r       <= '0;
      e_w       <= '0;
      e_x       <= '0;
      e_vpn     <= '0;
      e_asid    <= '0;
      e_pfn     <= '0;
      busy      <= 1'b0;
      pend_vpn  <= '0;
      pend_asid <= '0;
      pend_acc  <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_OK;
      rsp_pfn   <= '0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mem_rd    <= 1'b0;
      if (flush) begin
        for (int i = 0; i < N; i++) begin
          if (!e_pin[i]) e_vld[i] <= 1'b0;
        end
      end
      if (inv_valid && iv_hit) begin
        e_vld[iv_idx] <= 1'b0;
        e_pin[iv_idx] <= 1'b0;
      end
      if (accept) begin
        if (!in_range) begin
          rsp_valid <= 1'b1;
          rsp_code  <= RSP_RANGE;
          rsp_pfn   <= '0;
        end else if (lk_hit) begin
          rsp_valid <= 1'b1;
          rsp_code  <= hit_ok ? RSP_OK : RSP_DENY;
          rsp_pfn   <= hit_ok ? e_pfn[lk_idx] : '0;
        end else begin
          busy      <= 1'b1;
          mem_rd    <= 1'b1;
          mem_addr  <= pt_base + {{(PA_W - VPN_W){1'b0}}, req_vpn};
          pend_vpn  <= req_vpn;
          pend_asid <= req_asid;
          pend_acc  <= req_acc;
        end
      end
      if (busy && mem_rvalid) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        if (!mem_rdata[B_V]) begin
          rsp_code <= RSP_NOPAGE;
          rsp_pfn  <= '0;
        end else begin
          rsp_code <= fill_ok ? RSP_OK : RSP_DENY;
          rsp_pfn  <= fill_ok ? mem_rdata[PFN_W-1:0] : '0;
          if (vic_ok) begin
            e_vld[vic_idx]  <= 1'b1;
            e_pin[vic_idx]  <= mem_rdata[B_PIN];
            e_r[vic_idx]    <= mem_rdata[B_R];
            e_w[vic_idx]    <= mem_rdata[B_W];
            e_x[vic_idx]    <= mem_rdata[B_X];
            e_vpn[vic_idx]  <= pend_vpn;
            e_asid[vic_idx] <= pend_asid;
            e_pfn[vic_idx]  <= mem_rdata[PFN_W-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int VPN_W = 8,
  parameter int PFN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VPN_W-1:0] req_vpn,
  input logic [VPN_W:0]   pt_len,
  input logic             rsp_valid,
  input logic [1:0]       rsp_code,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic             mem_rd,
  input logic             mem_rvalid
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (req_ready && !rsp_valid && !mem_rd));

  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  assert_stall_on_read_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (!req_ready && !rsp_valid));

  assert_fill_completes_R5: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && mem_rvalid) |=> (rsp_valid && req_ready));

  assert_fault_no_frame_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != 2'd0) |-> (rsp_pfn == '0));

  assert_range_no_read_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && ({1'b0, req_vpn} >= pt_len))
      |=> (rsp_valid && rsp_code == 2'd3 && !mem_rd));
endmodule

bind xlate_cache xlate_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vpn(req_vpn), .pt_len(pt_len), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .rsp_pfn(rsp_pfn), .mem_rd(mem_rd), .mem_rvalid(mem_rvalid));

// File: tb/tb_xlate_cache.sv
`timescale 1ns/1ps
module tb_xlate_cache;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, rsp_valid, mem_rd, mem_rvalid, inv_valid, flush;
  logic [7:0]  req_vpn, rsp_pfn, inv_vpn;
  logic [3:0]  req_asid, inv_asid;
  logic [1:0]  req_acc, rsp_code;
  logic [15:0] pt_base, mem_addr;
  logic [8:0]  pt_len;
  logic [12:0] mem_rdata;

  logic [12:0] ptm [256];
  int   n_chk = 0, n_bad = 0;
  logic [1:0]  g_code;
  logic [7:0]  g_pfn;
  logic [15:0] g_addr;
  bit   g_rd, g_poke, g_flush_ret;

  always #2.5 clk = ~clk;

  xlate_cache dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn), .req_asid(req_asid),
    .req_acc(req_acc), .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_pfn(rsp_pfn), .pt_base(pt_base), .pt_len(pt_len), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .inv_asid(inv_asid), .flush(flush));

  function automatic logic [12:0] mk(input bit pin, input bit v, input bit x, input bit w,
                                     input bit r, input logic [7:0] pfn);
    return {pin, v, x, w, r, pfn};
  endfunction

  function automatic logic [7:0] xp(input logic [7:0] vpn);
    return vpn + 8'h40;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic [7:0] vpn, input logic [3:0] asid, input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = vpn; req_asid = asid; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    g_rd = 1'b0; g_code = 2'd0; g_pfn = 8'h00; g_addr = 16'h0;
    if (rsp_valid) begin
      g_code = rsp_code; g_pfn = rsp_pfn;
    end else if (mem_rd) begin
      g_rd = 1'b1; g_addr = mem_addr;
      for (int k = 0; k < 3; k++) begin
        if (g_poke) begin
          req_valid = 1'b1; req_vpn = 8'h01; req_asid = asid; req_acc = 2'd0;
        end
        @(negedge clk);
        if (g_poke)
          chk(!req_ready && !rsp_valid && !mem_rd, "R4 stall while refilling",
              {req_ready, rsp_valid, mem_rd}, 0);
      end
      req_valid = 1'b0;
      mem_rvalid = 1'b1; mem_rdata = ptm[8'(g_addr - 16'h1000)]; flush = g_flush_ret;
      @(negedge clk);
      mem_rvalid = 1'b0; flush = 1'b0;
      chk(rsp_valid && req_ready, "R5 response after fill", {rsp_valid, req_ready}, 3);
      g_code = rsp_code; g_pfn = rsp_pfn;
    end else begin
      chk(1'b0, "R2 no response and no read", 0, 1);
    end
  endtask

  task automatic do_inv(input logic [7:0] vpn, input logic [3:0] asid);
    @(negedge clk); inv_valid = 1'b1; inv_vpn = vpn; inv_asid = asid;
    @(negedge clk); inv_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic t_reset();
    chk(req_ready && !rsp_valid && !mem_rd, "R1 idle after reset",
        {req_ready, rsp_valid, mem_rd}, 4);
  endtask

  task automatic t_miss_hit();
    g_poke = 1'b1;
    do_req(8'd5, 4'd1, 2'd0);
    g_poke = 1'b0;
    chk(g_rd, "R1 first lookup misses", g_rd, 1);
    chk(g_addr == 16'h1005, "R4 read address", g_addr, 16'h1005);
    chk(g_code == 2'd0 && g_pfn == xp(8'd5), "R5 fill frame", g_pfn, xp(8'd5));
    do_req(8'd5, 4'd1, 2'd0);
    chk(!g_rd && g_code == 2'd0 && g_pfn == xp(8'd5), "R2 hit frame", g_pfn, xp(8'd5));
  endtask

  task automatic t_asid();
    do_req(8'd5, 4'd2, 2'd0);
    chk(g_rd, "R3 other identifier misses", g_rd, 1);
  endtask

  task automatic t_perm();
    do_req(8'd7, 4'd1, 2'd1);
    chk(g_rd && g_code == 2'd2 && g_pfn == 8'h00, "R7 write denied on fill", g_code, 2);
    do_req(8'd7, 4'd1, 2'd0);
    chk(!g_rd && g_code == 2'd0 && g_pfn == xp(8'd7), "R7 read allowed on hit", g_code, 0);
    do_req(8'd7, 4'd1, 2'd2);
    chk(!g_rd && g_code == 2'd2 && g_pfn == 8'h00, "R7 execute denied on hit", g_code, 2);
  endtask

  task automatic t_nopage();
    do_req(8'd9, 4'd1, 2'd0);
    chk(g_rd && g_code == 2'd1 && g_pfn == 8'h00, "R6 invalid entry fault", g_code, 1);
    do_req(8'd9, 4'd1, 2'd0);
    chk(g_rd, "R6 invalid entry not installed", g_rd, 1);
  endtask

  task automatic t_range();
    pt_len = 9'd16;
    do_req(8'd20, 4'd1, 2'd0);
    chk(!g_rd && g_code == 2'd3, "R8 beyond length", g_code, 3);
    do_req(8'd16, 4'd1, 2'd0);
    chk(!g_rd && g_code == 2'd3, "R8 at length", g_code, 3);
    do_req(8'd15, 4'd1, 2'd0);
    chk(g_rd && g_code == 2'd0, "R8 last entry in range", g_code, 0);
    pt_len = 9'd256;
  endtask

  task automatic t_flush_pin();
    do_flush();
    do_req(8'd2, 4'd1, 2'd0);
    do_req(8'd3, 4'd1, 2'd0);
    do_flush();
    do_req(8'd2, 4'd1, 2'd0);
    chk(!g_rd && g_pfn == xp(8'd2), "R9 pinned entry survives flush", g_rd, 0);
    do_req(8'd3, 4'd1, 2'd0);
    chk(g_rd, "R9 unpinned entry flushed", g_rd, 1);
  endtask

  task automatic t_inval();
    do_inv(8'd2, 4'd1);
    do_req(8'd3, 4'd1, 2'd0);
    chk(!g_rd, "R10 other entry kept", g_rd, 0);
    do_req(8'd2, 4'd1, 2'd0);
    chk(g_rd, "R10 pinned entry invalidated", g_rd, 1);
    do_inv(8'd2, 4'd1);
  endtask

  task automatic t_lru();
    do_flush();
    for (int v = 30; v < 34; v++) do_req(8'(v), 4'd3, 2'd0);
    do_req(8'd30, 4'd3, 2'd0);
    do_req(8'd34, 4'd3, 2'd0);
    do_req(8'd30, 4'd3, 2'd0);
    chk(!g_rd, "R11 recently used kept", g_rd, 0);
    do_req(8'd32, 4'd3, 2'd0);
    chk(!g_rd, "R11 newer entry kept", g_rd, 0);
    do_req(8'd34, 4'd3, 2'd0);
    chk(!g_rd, "R11 new fill held", g_rd, 0);
    do_req(8'd31, 4'd3, 2'd0);
    chk(g_rd, "R11 oldest evicted", g_rd, 1);
    do_flush();
    for (int v = 40; v < 44; v++) do_req(8'(v), 4'd3, 2'd0);
    do_req(8'd44, 4'd3, 2'd0);
    do_req(8'd40, 4'd3, 2'd0);
    chk(!g_rd, "R11 pinned oldest not evicted", g_rd, 0);
    do_req(8'd41, 4'd3, 2'd0);
    chk(g_rd, "R11 oldest unpinned evicted", g_rd, 1);
    do_inv(8'd40, 4'd3);
  endtask

  task automatic t_same_cycle();
    do_req(8'd50, 4'd4, 2'd0);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = 8'd50; req_asid = 4'd4; req_acc = 2'd0;
    inv_valid = 1'b1; inv_vpn = 8'd50; inv_asid = 4'd4;
    @(negedge clk);
    req_valid = 1'b0; inv_valid = 1'b0;
    chk(rsp_valid && !mem_rd && rsp_code == 2'd0 && rsp_pfn == xp(8'd50),
        "R12 lookup sees entry before invalidate", rsp_pfn, xp(8'd50));
    do_req(8'd50, 4'd4, 2'd0);
    chk(g_rd, "R12 entry gone after invalidate", g_rd, 1);
    g_flush_ret = 1'b1;
    do_req(8'd51, 4'd4, 2'd0);
    g_flush_ret = 1'b0;
    do_req(8'd51, 4'd4, 2'd0);
    chk(!g_rd, "R12 fill installed despite flush", g_rd, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ptm[i] = mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, xp(8'(i)));
    ptm[7]  = mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, xp(8'd7));
    ptm[9]  = mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, xp(8'd9));
    ptm[2]  = mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, xp(8'd2));
    ptm[40] = mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, xp(8'd40));
    rst = 1'b1; req_valid = 1'b0; req_vpn = '0; req_asid = '0; req_acc = '0;
    mem_rvalid = 1'b0; mem_rdata = '0; inv_valid = 1'b0; inv_vpn = '0; inv_asid = '0;
    flush = 1'b0; pt_base = 16'h1000; pt_len = 9'd256; g_poke = 1'b0; g_flush_ret = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_asid();
    t_perm();
    t_nopage();
    t_range();
    t_flush_pin();
    t_inval();
    t_lru();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule